// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out store for 9-bit words. The writer and the reader each run on their own clock. Writes and reads are requested with active-low enables. Four active-low status flags report the state of the store. The empty and almost-empty flags are produced in the read clock domain. The full and almost-full flags are produced in the write clock domain. The two almost thresholds live in offset registers.

The offset registers are reached through the ordinary data ports. While the active-low load line is low, a write goes to an offset register and does not touch the array. A read in the same mode places an offset register on the output bus. The accesses alternate between the two registers: the almost-empty offset first, then the almost-full offset. A retransmit strobe in the read domain moves the read position back to the first word stored since reset, so a short message can be replayed. The output bus goes to high impedance when output enable is high. The depth is a power of two set by a parameter.

Top module: `fifo_dc_progflags`

## Requirements
- R1: On a rising write clock edge with `wr_en_n` low, `cfg_n` high and `full_n` high, `din` is stored. Words come out in the order they were written.
- R2: On a rising read clock edge with `rd_en_n` low, `cfg_n` high and `empty_n` high, the oldest word is driven on `dout` after that edge. A read request while empty leaves `dout` and the stored contents unchanged.
- R3: `full_n` is low when 2^ADDR_W words are held. A write attempted while full is discarded.
- R4: `empty_n` is low when no word is held as seen from the read clock domain.
- R5: `aempty_n` is low when the read-side fill level is less than or equal to the almost-empty offset.
- R6: `afull_n` is low when the write-side free space is less than or equal to the almost-full offset.
- R7: A write clock edge with `cfg_n` low and `wr_en_n` low loads `din[ADDR_W:0]` into an offset register and leaves the array and write position unchanged. Successive loads alternate almost-empty, almost-full, almost-empty, and so on.
- R8: A read clock edge with `cfg_n` low and `rd_en_n` low drives the selected offset, zero-extended, onto `dout`. Successive readbacks alternate almost-empty, then almost-full.
- R9: When `rst_n` is low, the FIFO empties, both offsets become OFF_DEF (7), and both alternation selectors return to the almost-empty offset.
- R10: When `oe_n` is high, `dout` is high impedance. When `oe_n` is low, `dout` drives the output register.
- R11: A read clock edge with `retx` high sets the read position back to the first word stored since reset and takes priority over a read. The write position is left as it is.
- R12: The fill level seen by the write side never exceeds 2^ADDR_W. The full flag implies the almost-full flag, and the empty flag implies the almost-empty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| din | input | DATA_W | Write data or offset value |
| rd_en_n | input | 1 | Read enable, active low |
| cfg_n | input | 1 | Offset register access select, active low |
| retx | input | 1 | Retransmit strobe, read domain |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Read data, high impedance when disabled |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
The assertions check on every cycle that the write position cannot move while full or in load mode, and that the read position cannot move while empty or in load mode unless a retransmit is in progress. They also check that the occupancy seen by the writer stays within the depth and that each hard flag implies its almost flag. Only the bench scenarios can show that the data survives in order across pointer wrap and retransmit, that the flag thresholds sit exactly at the programmed offsets, that the offset readback alternates, and that the bus releases to high impedance.

// File: rtl/fifo_dc_progflags.sv
module fifo_dc_progflags #(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 4,
  parameter int OFF_DEF = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en_n,
  input  logic              cfg_n,
  input  logic              retx,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              empty_n,
  output logic              aempty_n,
  output logic              full_n,
  output logic              afull_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] OFF_P   = PW'(OFF_DEF);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [PW-1:0] ae_off, af_off;
  logic          wsel, rsel;
  logic [DATA_W-1:0] dout_q;

  // write domain
  logic [PW-1:0] wbin_nx, rbin_w, wr_used, wr_free;
  logic          wr_do, cfg_wr;

  assign wbin_nx = wbin + 1'b1;
  assign rbin_w  = from_gray(rg_s2);
  assign wr_used = wbin - rbin_w;
  assign wr_free = DEPTH_P - wr_used;
  assign full_n  = (wr_used != DEPTH_P);
  assign afull_n = (wr_free > af_off);
  assign wr_do   = !wr_en_n && cfg_n && full_n;
  assign cfg_wr  = !wr_en_n && !cfg_n;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      ae_off <= OFF_P;
      af_off <= OFF_P;
      wsel   <= 1'b0;
      rg_s1  <= '0;
      rg_s2  <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_do) begin
        wbin  <= wbin_nx;
        wgray <= to_gray(wbin_nx);
      end
      if (cfg_wr) begin
        if (!wsel) ae_off <= din[PW-1:0];
        else       af_off <= din[PW-1:0];
        wsel <= !wsel;
      end
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_do) mem[wbin[ADDR_W-1:0]] <= din;
  end

  // read domain
  logic [PW-1:0] rbin_nx, wbin_r, rd_used;
  logic          rd_do, cfg_rd;

  assign rbin_nx  = rbin + 1'b1;
  assign wbin_r   = from_gray(wg_s2);
  assign rd_used  = wbin_r - rbin;
  assign empty_n  = (rd_used != '0);
  assign aempty_n = (rd_used > ae_off);
  assign rd_do    = !rd_en_n && cfg_n && empty_n && !retx;
  assign cfg_rd   = !rd_en_n && !cfg_n;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      rsel   <= 1'b0;
      dout_q <= '0;
      wg_s1  <= '0;
      wg_s2  <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (retx) begin
        rbin  <= '0;
        rgray <= '0;
      end else if (rd_do) begin
        rbin   <= rbin_nx;
        rgray  <= to_gray(rbin_nx);
        dout_q <= mem[rbin[ADDR_W-1:0]];
      end
      if (cfg_rd) begin
        dout_q <= DATA_W'(rsel ? af_off : ae_off);
        rsel   <= !rsel;
      end
    end
  end

  assign dout = oe_n ? {DATA_W{1'bz}} : dout_q;

  // checks
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));
  assert_cfg_wr_holds_ptr_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !cfg_n |=> $stable(wbin));
  assert_no_underflow_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !retx) |=> $stable(rbin));
  assert_cfg_rd_holds_ptr_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!cfg_n && !retx) |=> $stable(rbin));
  assert_retx_rewinds_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
    retx |=> (rbin == '0));
  assert_used_bound_R12: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_used <= DEPTH_P);
  assert_full_implies_af_R12: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  assert_empty_implies_ae_R12: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
endmodule

// File: tb/test_fifo_dc_progflags.sv
module test_fifo_dc_progflags;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en_n = 1, rd_en_n = 1, cfg_n = 1, retx = 0, oe_n = 1;
  logic [DW-1:0] din = '0;
  wire  [DW-1:0] dout;
  logic empty_n, aempty_n, full_n, afull_n;
  int checks = 0, errors = 0;

  always #4 wr_clk = ~wr_clk;
  always #5 rd_clk = ~rd_clk;

  fifo_dc_progflags #(.DATA_W(DW), .ADDR_W(AW), .OFF_DEF(7)) i_fifo_dc_progflags (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .din(din),
    .rd_en_n(rd_en_n), .cfg_n(cfg_n), .retx(retx), .oe_n(oe_n), .dout(dout),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n));

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) & 9'h1FF);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic wr_word(input logic [DW-1:0] v);
    @(negedge wr_clk);
    wr_en_n = 0; din = v;
    @(negedge wr_clk);
    wr_en_n = 1;
  endtask

  task automatic rd_word(output logic [DW-1:0] v);
    @(negedge rd_clk);
    rd_en_n = 0;
    @(negedge rd_clk);
    rd_en_n = 1;
    v = dout;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1;
    settle();
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    do_reset();
    // R9 reset state, R10 high impedance
    chk(empty_n === 0 && aempty_n === 0, "R9", {empty_n, aempty_n}, 0);
    chk(full_n === 1 && afull_n === 1, "R9", {full_n, afull_n}, 3);
    chk(dout === {DW{1'bz}}, "R10", dout, -1);
    oe_n = 0; #1;
    chk(dout === '0, "R10", dout, 0);

    // R8 default offsets, alternation R9
    cfg_n = 0; settle();
    rd_word(v); chk(v === 7, "R8", v, 7);
    rd_word(v); chk(v === 7, "R8", v, 7);
    // R7 program AE=3, AF=5
    wr_word(9'd3); wr_word(9'd5); settle();
    chk(empty_n === 0, "R7", empty_n, 0);
    rd_word(v); chk(v === 3, "R7", v, 3);
    rd_word(v); chk(v === 5, "R8", v, 5);
    rd_word(v); chk(v === 3, "R8", v, 3);
    rd_word(v); chk(v === 5, "R8", v, 5);
    cfg_n = 1; settle();

    // R1 R3 R5 R6 fill sweep
    for (int n = 1; n <= DEPTH; n++) begin
      wr_word(pat(n - 1)); settle();
      chk(empty_n === 1, "R4", empty_n, 1);
      chk(full_n === (n != DEPTH), "R3", full_n, n != DEPTH);
      chk(aempty_n === (n > 3), "R5", aempty_n, n > 3);
      chk(afull_n === (n < DEPTH - 5), "R6", afull_n, n < DEPTH - 5);
    end
    wr_word(9'h155); settle();
    chk(full_n === 0, "R3", full_n, 0);

    // R2 drain, R4 R5
    for (int k = 1; k <= DEPTH; k++) begin
      rd_word(v);
      chk(v === pat(k - 1), "R1", v, pat(k - 1));
      settle();
      chk(empty_n === (k < DEPTH), "R4", empty_n, k < DEPTH);
      chk(aempty_n === (DEPTH - k > 3), "R5", aempty_n, DEPTH - k > 3);
      chk(full_n === 1, "R3", full_n, 1);
    end
    rd_word(v);
    chk(v === pat(DEPTH - 1), "R2", v, pat(DEPTH - 1));
    oe_n = 1; #1;
    chk(dout === {DW{1'bz}}, "R10", dout, -1);
    oe_n = 0;

    // R9 reset restores offsets
    do_reset();
    cfg_n = 0; settle();
    rd_word(v); chk(v === 7, "R9", v, 7);
    rd_word(v); chk(v === 7, "R9", v, 7);
    cfg_n = 1; settle();

    // R1 pointer wrap
    for (int i = 0; i < 40; i++) begin
      wr_word(pat(i + 100)); settle();
      rd_word(v);
      chk(v === pat(i + 100), "R1", v, pat(i + 100));
    end

    // R11 retransmit
    do_reset();
    for (int i = 0; i < 5; i++) wr_word(pat(i + 200));
    settle();
    for (int i = 0; i < 3; i++) begin
      rd_word(v); chk(v === pat(i + 200), "R2", v, pat(i + 200));
    end
    @(negedge rd_clk); retx = 1;
    @(negedge rd_clk); retx = 0;
    settle();
    chk(empty_n === 1 && aempty_n === 0, "R11", {empty_n, aempty_n}, 2);
    for (int i = 0; i < 5; i++) begin
      rd_word(v); chk(v === pat(i + 200), "R11", v, pat(i + 200));
    end
    settle();
    chk(empty_n === 0, "R11", empty_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule